// File: doc/BRIEF.md
# Conversion Result Buffer with Ready Flag

This block sits between a converter's result path and a serial host port. It holds the newest conversion word in an output register for the host to read. It signals a waiting word with an active-low ready flag. The converter delivers each result as a one-cycle valid strobe with a data word. The serial port reports the start and the end of each output-register read with two strobes.

A read that is under way is never disturbed. A result that lands during a read goes into a one-word side slot, and a later result during the same read replaces it. When the read ends, the flag is released at once. A word waiting in the side slot moves to the output register in the same cycle, and the flag is lowered again only after a programmable minimum high time.

Two other inputs act on the flag. A control-register write that targets the filter or mode bytes releases the flag and, if a calibration mode is selected, raises a one-cycle recalibration request. A standby input holds the flag high and drops incoming results.

Top module: `conv_result_buffer`

## Requirements
- R1: After reset `ready_n` is 1, `dout` is all zeros and `recal_req` is 0.
- R2: When no read is in progress and `standby` is 0, a `res_valid` strobe loads `res_data` into `dout` on the next cycle, and `ready_n` goes to 0 once no minimum-high window is running.
- R3: While a read is in progress (after `rd_start`, before `rd_done`), arriving results leave `dout` unchanged and do not raise `ready_n`.
- R4: Of several results that arrive during one read, only the last one is kept in the side slot and later presented on `dout`.
- R5: A `rd_done` strobe during a read drives `ready_n` to 1 on the next cycle. If the side slot is empty, `ready_n` stays 1 until a new result arrives.
- R6: If the side slot holds a word when `rd_done` is strobed, `dout` shows that word on the next cycle, and `ready_n` stays 1 for exactly `MIN_HIGH` cycles before going to 0.
- R7: A control write with `ctl_byte` equal to 1 or 2 drives `ready_n` to 1 on the next cycle. It also pulses `recal_req` for one cycle when `cal_mode` is 1, and leaves it at 0 otherwise.
- R8: A control write with `ctl_byte` equal to 0 leaves `ready_n` unchanged and keeps `recal_req` at 0.
- R9: While `standby` is 1, `ready_n` is 1 and `res_valid` strobes are ignored (`dout` unchanged). After `standby` returns to 0, `ready_n` stays 1 until a new result arrives.
- R10: A result that arrives without a read during the minimum-high window updates `dout` at once, but `ready_n` stays 1 until `MIN_HIGH` cycles have passed since the `rd_done` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | One-cycle strobe: a new conversion result is on `res_data` |
| res_data | input | DATA_W | Conversion result word |
| rd_start | input | 1 | Serial port has begun reading the output register |
| rd_done | input | 1 | Serial port has finished reading the output register |
| ctl_wr | input | 1 | Control-register byte write strobe |
| ctl_byte | input | 2 | Index of the control byte written (0, 1 or 2) |
| cal_mode | input | 1 | The written control value selects a calibration mode |
| standby | input | 1 | Standby level: flag held high, results dropped |
| dout | output | DATA_W | Output register contents |
| ready_n | output | 1 | Active-low result-ready flag |
| recal_req | output | 1 | One-cycle recalibration request |

## Verification
The hardest state to reach is a read ending while the side slot is full. Reaching it needs a fresh result, a read opened on it, and then one or more further results landing strictly inside the read window. The bench sweeps the number of in-read arrivals from zero to three, with distinct data words each time. After each `rd_done` it counts the cycles that `ready_n` stays high, so the side-slot promotion, the replacement order and the minimum-high window are all checked from the ports. The same window is then re-entered with a result that arrives without a read, which separates the hold timer from the side slot.

// File: rtl/crb_pkg.sv
package crb_pkg;

  // Next value of the flag-hold countdown: load on release, else count to zero.
  function automatic int unsigned hold_step(input int unsigned cnt,
                                            input bit load,
                                            input int unsigned lim);
    if (load)
      return lim;
    else if (cnt != 0)
      return cnt - 1;
    else
      return 0;
  endfunction

  // Control bytes that reprogram filter or mode release the flag.
  function automatic bit byte_releases(input logic [1:0] idx);
    return (idx == 2'd1) || (idx == 2'd2);
  endfunction

endpackage

// File: rtl/crb_hold_timer.sv
module crb_hold_timer #(
  parameter int unsigned MIN_HIGH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic hold_zero
);
  localparam int unsigned HW = $clog2(MIN_HIGH + 1);

  logic [HW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else
      cnt <= HW'(crb_pkg::hold_step(int'(cnt), load, MIN_HIGH));
  end

  assign hold_zero = (cnt == '0);
endmodule

// File: rtl/crb_side_slot.sv
module crb_side_slot #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              drop,
  output logic              slot_vld,
  output logic [DATA_W-1:0] slot_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_vld  <= 1'b0;
      slot_data <= '0;
    end else if (drop) begin
      slot_vld  <= 1'b0;
    end else if (capture) begin
      slot_vld  <= 1'b1;
      slot_data <= cap_data;
    end
  end
endmodule

// File: rtl/crb_out_ctrl.sv
module crb_out_ctrl #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_read,
  input  logic              close_read,
  input  logic              load_out,
  input  logic [DATA_W-1:0] load_data,
  input  logic              clear_avail,
  output logic              reading,
  output logic              avail,
  output logic [DATA_W-1:0] out_word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reading  <= 1'b0;
      avail    <= 1'b0;
      out_word <= '0;
    end else begin
      if (close_read)
        reading <= 1'b0;
      else if (open_read)
        reading <= 1'b1;

      if (load_out)
        out_word <= load_data;

      if (clear_avail)
        avail <= 1'b0;
      else if (load_out)
        avail <= 1'b1;
      else if (close_read)
        avail <= 1'b0;
    end
  end
endmodule

// File: rtl/conv_result_buffer.sv
module conv_result_buffer #(
  parameter int unsigned DATA_W   = 24,
  parameter int unsigned MIN_HIGH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic              rd_start,
  input  logic              rd_done,
  input  logic              ctl_wr,
  input  logic [1:0]        ctl_byte,
  input  logic              cal_mode,
  input  logic              standby,
  output logic [DATA_W-1:0] dout,
  output logic              ready_n,
  output logic              recal_req
);
  // Named internal events
  logic              reading;
  logic              avail;
  logic              hold_zero;
  logic              slot_vld;
  logic [DATA_W-1:0] slot_data;
  logic              ev_accept;
  logic              ev_release;
  logic              ev_direct;
  logic              ev_divert;
  logic              ev_promote;
  logic              ev_flush;
  logic              load_out;
  logic [DATA_W-1:0] load_data;

  assign ev_accept  = res_valid & ~standby;
  assign ev_release = rd_done & reading;
  assign ev_direct  = ev_accept & ~reading;
  assign ev_divert  = ev_accept & reading & ~ev_release;
  assign ev_promote = ev_release & (ev_accept | slot_vld);
  assign ev_flush   = ctl_wr & crb_pkg::byte_releases(ctl_byte);

  assign load_out  = ev_direct | ev_promote;
  assign load_data = (ev_direct | ev_accept) ? res_data : slot_data;

  crb_out_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .open_read   (rd_start),
    .close_read  (ev_release),
    .load_out    (load_out),
    .load_data   (load_data),
    .clear_avail (ev_flush | standby),
    .reading     (reading),
    .avail       (avail),
    .out_word    (dout)
  );

  crb_side_slot #(.DATA_W(DATA_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (ev_divert),
    .cap_data  (res_data),
    .drop      (ev_release | ev_flush | standby),
    .slot_vld  (slot_vld),
    .slot_data (slot_data)
  );

  crb_hold_timer #(.MIN_HIGH(MIN_HIGH)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_release),
    .hold_zero (hold_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      recal_req <= 1'b0;
    else
      recal_req <= ev_flush & cal_mode;
  end

  assign ready_n = standby | ~(avail & hold_zero);
endmodule

// File: rtl/conv_result_buffer_chk.sv
module conv_result_buffer_chk #(
  parameter int unsigned DATA_W   = 24,
  parameter int unsigned MIN_HIGH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_data,
  input logic              rd_done,
  input logic              ctl_wr,
  input logic [1:0]        ctl_byte,
  input logic              cal_mode,
  input logic              standby,
  input logic [DATA_W-1:0] dout,
  input logic              ready_n,
  input logic              recal_req,
  input logic              reading,
  input logic              ev_release
);
  localparam int unsigned CW = $clog2(MIN_HIGH + 1);
  logic [CW-1:0] since_rel;

  always_ff @(posedge clk) begin
    if (!rst_n)
      since_rel <= CW'(MIN_HIGH);
    else if (ev_release)
      since_rel <= '0;
    else if (since_rel != CW'(MIN_HIGH))
      since_rel <= since_rel + 1'b1;
  end

  a_r9_standby_high: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> ready_n);

  a_r3_read_keeps_dout: assert property (@(posedge clk) disable iff (!rst_n)
    (reading && !rd_done) |=> $stable(dout));

  a_r2_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !standby && !reading) |=> dout == $past(res_data));

  a_r7_recal_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && (ctl_byte == 2'd1 || ctl_byte == 2'd2) && cal_mode) |=> recal_req);

  a_r8_no_recal: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_wr && (ctl_byte == 2'd1 || ctl_byte == 2'd2) && cal_mode) |=> !recal_req);

  a_r6_min_high: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_n |-> since_rel == CW'(MIN_HIGH));

  a_r5_release_high: assert property (@(posedge clk) disable iff (!rst_n)
    ev_release |=> ready_n);
endmodule

bind conv_result_buffer conv_result_buffer_chk #(.DATA_W(DATA_W), .MIN_HIGH(MIN_HIGH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .res_valid  (res_valid),
  .res_data   (res_data),
  .rd_done    (rd_done),
  .ctl_wr     (ctl_wr),
  .ctl_byte   (ctl_byte),
  .cal_mode   (cal_mode),
  .standby    (standby),
  .dout       (dout),
  .ready_n    (ready_n),
  .recal_req  (recal_req),
  .reading    (reading),
  .ev_release (ev_release)
);

// File: tb/tb_conv_result_buffer.sv
module tb_conv_result_buffer;
  localparam int unsigned DW = 24;
  localparam int unsigned MH = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          res_valid = 1'b0;
  logic [DW-1:0] res_data = '0;
  logic          rd_start = 1'b0;
  logic          rd_done = 1'b0;
  logic          ctl_wr = 1'b0;
  logic [1:0]    ctl_byte = 2'd0;
  logic          cal_mode = 1'b0;
  logic          standby = 1'b0;
  logic [DW-1:0] dout;
  logic          ready_n;
  logic          recal_req;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] shown;

  always #10 clk = ~clk;

  conv_result_buffer #(.DATA_W(DW), .MIN_HIGH(MH)) dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .rd_start(rd_start), .rd_done(rd_done), .ctl_wr(ctl_wr), .ctl_byte(ctl_byte),
    .cal_mode(cal_mode), .standby(standby), .dout(dout), .ready_n(ready_n),
    .recal_req(recal_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int b);
    return DW'((a * 32'h00A5_1C37) ^ (b * 32'h0013_5F11) ^ 32'h5A_0F3C);
  endfunction

  // Each step: drive just after a falling edge, return on the next falling edge.
  task automatic step;
    @(negedge clk);
    res_valid = 1'b0; rd_start = 1'b0; rd_done = 1'b0; ctl_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic put(input logic [DW-1:0] d);
    res_valid = 1'b1; res_data = d; step();
  endtask

  // Count cycles with ready_n high, up to a limit.
  task automatic count_high(output int c, input int lim);
    c = 0;
    while (ready_n && c < lim) begin c++; step(); end
  endtask

  initial begin
    int hc;
    idle(2);
    chk("R1 ready_n", ready_n, 1);
    chk("R1 dout", dout, 0);
    chk("R1 recal_req", recal_req, 0);
    rst_n = 1'b1;
    step();
    chk("R1 ready_n after release", ready_n, 1);

    // R2: direct loads over a sweep of data words
    for (int i = 0; i < 8; i++) begin
      put(pat(i, 1));
      chk("R2 dout", dout, pat(i, 1));
      chk("R2 ready_n", ready_n, 0);
    end
    shown = pat(7, 1);

    // R3/R4/R5/R6: reads with 0..3 results arriving inside the read
    for (int n = 0; n < 4; n++) begin
      put(pat(n, 2));
      shown = pat(n, 2);
      rd_start = 1'b1; step();
      for (int k = 0; k < n; k++) begin
        put(pat(n, 10 + k));
        chk("R3 dout held", dout, shown);
        chk("R3 ready_n low", ready_n, 0);
      end
      rd_done = 1'b1; step();
      chk("R5 ready_n released", ready_n, 1);
      if (n == 0) begin
        chk("R5 dout kept", dout, shown);
        idle(MH + 3);
        chk("R5 ready_n stays high", ready_n, 1);
      end else begin
        chk("R4 dout last word", dout, pat(n, 10 + n - 1));
        count_high(hc, MH + 4);
        chk("R6 high cycles", hc, MH);
        chk("R6 ready_n low", ready_n, 0);
      end
    end

    // R10: direct result during the hold window
    put(pat(3, 3));
    rd_start = 1'b1; step();
    rd_done = 1'b1; step();
    put(pat(4, 3));
    chk("R10 dout updated", dout, pat(4, 3));
    count_high(hc, MH + 4);
    chk("R10 high cycles after done", hc, MH - 1);
    chk("R10 ready_n low", ready_n, 0);

    // R7/R8: control byte sweep with and without calibration mode
    for (int b = 0; b < 3; b++) begin
      for (int c = 0; c < 2; c++) begin
        put(pat(b, c + 20));
        chk("R2 ready_n before ctl", ready_n, 0);
        ctl_wr = 1'b1; ctl_byte = 2'(b); cal_mode = c[0]; step();
        if (b == 0) begin
          chk("R8 ready_n unchanged", ready_n, 0);
          chk("R8 recal_req", recal_req, 0);
        end else begin
          chk("R7 ready_n", ready_n, 1);
          chk("R7 recal_req", recal_req, (c == 1) ? 1 : 0);
        end
        step();
        chk("R7 recal one cycle", recal_req, 0);
        cal_mode = 1'b0;
      end
    end

    // R9: standby
    put(pat(9, 9));
    shown = pat(9, 9);
    standby = 1'b1; step();
    chk("R9 ready_n in standby", ready_n, 1);
    put(pat(9, 10));
    chk("R9 dout ignored", dout, shown);
    chk("R9 ready_n held", ready_n, 1);
    standby = 1'b0; step();
    chk("R9 ready_n after standby", ready_n, 1);
    put(pat(9, 11));
    chk("R9 new result after standby", dout, pat(9, 11));
    chk("R9 ready_n low again", ready_n, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule